// File: doc/BRIEF.md
# Three-Stage Program Counter Tracker

This block keeps the program counter of a small in-order core with a fetch, decode and execute stage. It produces a word-aligned fetch address each cycle. It records the address of the instruction that sits in each stage, together with a valid bit for that stage. Instruction decode, the register file and memory sit outside the block.

An instruction in execute that reads the PC as a source operand sees a fixed architectural value: its own address plus 8. When that instruction is a supervisor call, the return address is its own address plus 4. The block writes that address out with a one-cycle strobe, drops the two younger instructions and restarts fetch at the exception vector. A branch resolved in execute flushes the same way and restarts fetch at the branch target. Both offsets come from the executing instruction's own recorded address, so stalls and bubbles cannot change them.

Top module: `pc_tracker`

## Requirements
- R1: While `rst_n` is low, `fetch_addr_o` is 0 and `stage_vld_o` is 3'b000. Reset acts at once, without waiting for a clock edge.
- R2: On every clock edge without stall or redirect, `fetch_addr_o` rises by 4. The fetched address enters the fetch stage as valid, and each stage passes its contents to the next. `stage_vld_o` bit 0 is fetch, bit 1 is decode and bit 2 is execute.
- R3: When the execute stage is valid, `opnd_pc_o` equals the executing instruction's address plus 8.
- R4: `link_we_o` is high only when `svc_i` is high, the execute stage is valid and `stall_i` is low. In that cycle `link_addr_o` equals the executing instruction's address plus 4.
- R5: After a cycle with `link_we_o` high, all three valid bits are clear and `fetch_addr_o` is 0x00000008.
- R6: When the execute stage is valid, `br_take_i` is high, `svc_i` is low and there is no stall, the next cycle has all valid bits clear. In that cycle `fetch_addr_o` equals `br_target_i` with bits [1:0] forced to zero.
- R7: A cycle with `stall_i` high leaves `fetch_addr_o`, the stage contents and `stage_vld_o` unchanged. A supervisor call or branch presented during that cycle has no effect and gives no link strobe.
- R8: When `svc_i` and `br_take_i` are high together on a valid, unstalled execute stage, the supervisor call wins. The link is written and fetch goes to the vector, not to the branch target.
- R9: If `svc_i` or `br_take_i` arrives while the execute stage is invalid, it has no effect. There is no strobe and fetch continues in sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall_i | input | 1 | Freeze the fetch PC and all stages |
| svc_i | input | 1 | Instruction in execute is a supervisor call |
| br_take_i | input | 1 | Instruction in execute redirects to a branch target |
| br_target_i | input | 32 | Branch target byte address |
| fetch_addr_o | output | 32 | Word-aligned fetch address |
| opnd_pc_o | output | 32 | PC value an executing instruction reads |
| link_addr_o | output | 32 | Return address for the supervisor call |
| link_we_o | output | 1 | Write strobe for `link_addr_o` |
| stage_vld_o | output | 3 | Valid bits {execute, decode, fetch} |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the supervisor call and the branch redirect. The bench raises both on one valid execute instruction and expects the link strobe, the return address and a restart at 0x8 rather than at the branch target. The second pair is stall and a supervisor call. The bench holds an SVC in execute under stall and expects no strobe until the stall drops, then exactly one. The same collisions on an invalid execute stage, just after a flush, must leave the fetch sequence untouched.

// File: rtl/pc_trk_pkg.sv
package pc_trk_pkg;
  parameter int ADDR_W  = 32;
  parameter int NSTAGE  = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t addr;
    logic  valid;
  } stage_t;
endpackage

// File: rtl/pc_fetch_ctr.sv
module pc_fetch_ctr
  import pc_trk_pkg::*;
#(
  parameter addr_t VEC_ADDR   = 32'h0000_0008,
  parameter int    STEP_BYTES = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_en,
  input  logic  svc_redir,
  input  logic  br_redir,
  input  addr_t br_tgt,
  output addr_t fpc_q
);
  localparam addr_t STEP = addr_t'(STEP_BYTES);

  addr_t fpc_d;

  always_comb begin
    fpc_d = fpc_q;
    if (svc_redir)      fpc_d = VEC_ADDR;
    else if (br_redir)  fpc_d = {br_tgt[ADDR_W-1:2], 2'b00};
    else if (adv_en)    fpc_d = fpc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fpc_q <= '0;
    else        fpc_q <= fpc_d;
  end
endmodule

// File: rtl/pc_stage_reg.sv
module pc_stage_reg
  import pc_trk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   kill,
  input  stage_t d_in,
  output stage_t q
);
  stage_t nxt;

  always_comb begin
    nxt = q;
    if (en) begin
      nxt.addr  = d_in.addr;
      nxt.valid = d_in.valid & ~kill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/pc_arch_view.sv
module pc_arch_view
  import pc_trk_pkg::*;
#(
  parameter int STEP_BYTES = 4
) (
  input  addr_t exe_addr,
  output addr_t opnd_pc,
  output addr_t link_addr
);
  localparam addr_t OPND_AHEAD = addr_t'(2 * STEP_BYTES);
  localparam addr_t LINK_AHEAD = addr_t'(STEP_BYTES);

  assign opnd_pc   = exe_addr + OPND_AHEAD;
  assign link_addr = exe_addr + LINK_AHEAD;
endmodule

// File: rtl/pc_tracker.sv
module pc_tracker
  import pc_trk_pkg::*;
#(
  parameter logic [31:0] VEC_ADDR   = 32'h0000_0008,
  parameter int          STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              svc_i,
  input  logic              br_take_i,
  input  logic [31:0]       br_target_i,
  output logic [31:0]       fetch_addr_o,
  output logic [31:0]       opnd_pc_o,
  output logic [31:0]       link_addr_o,
  output logic              link_we_o,
  output logic [NSTAGE-1:0] stage_vld_o
);
  localparam int EXE = NSTAGE - 1;

  stage_t chain [NSTAGE+1];
  addr_t  fpc;
  logic   adv_en, exe_live, svc_fire, br_fire, flush;

  assign adv_en   = ~stall_i;
  assign exe_live = chain[NSTAGE].valid & ~stall_i;
  assign svc_fire = exe_live & svc_i;
  assign br_fire  = exe_live & br_take_i & ~svc_i;
  assign flush    = svc_fire | br_fire;

  pc_fetch_ctr #(
    .VEC_ADDR   (addr_t'(VEC_ADDR)),
    .STEP_BYTES (STEP_BYTES)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_en    (adv_en),
    .svc_redir (svc_fire),
    .br_redir  (br_fire),
    .br_tgt    (br_target_i),
    .fpc_q     (fpc)
  );

  assign chain[0].addr  = fpc;
  assign chain[0].valid = 1'b1;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    pc_stage_reg u_stg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv_en),
      .kill  (flush),
      .d_in  (chain[s]),
      .q     (chain[s+1])
    );
    assign stage_vld_o[s] = chain[s+1].valid;
  end

  pc_arch_view #(
    .STEP_BYTES (STEP_BYTES)
  ) u_view (
    .exe_addr  (chain[EXE+1].addr),
    .opnd_pc   (opnd_pc_o),
    .link_addr (link_addr_o)
  );

  assign fetch_addr_o = fpc;
  assign link_we_o    = svc_fire;
endmodule

// File: rtl/pc_tracker_chk.sv
module pc_tracker_chk #(
  parameter logic [31:0] VEC_ADDR = 32'h0000_0008
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stall_i,
  input logic        svc_i,
  input logic        br_take_i,
  input logic [31:0] br_target_i,
  input logic [31:0] fetch_addr_o,
  input logic [31:0] opnd_pc_o,
  input logic [31:0] link_addr_o,
  input logic        link_we_o,
  input logic [2:0]  stage_vld_o
);
  assert_link_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (stage_vld_o[2] && !stall_i && svc_i));

  assert_link_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_addr_o == opnd_pc_o - 32'd4));

  assert_svc_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |=> (fetch_addr_o == VEC_ADDR && stage_vld_o == 3'b000));

  assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_vld_o[2] && br_take_i && !svc_i && !stall_i)
      |=> (fetch_addr_o == {$past(br_target_i[31:2]), 2'b00} && stage_vld_o == 3'b000));

  assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(fetch_addr_o) && $stable(stage_vld_o) && $stable(opnd_pc_o)));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !(stage_vld_o[2] && (svc_i || br_take_i)))
      |=> (fetch_addr_o == $past(fetch_addr_o) + 32'd4 && stage_vld_o[0]));
endmodule

bind pc_tracker pc_tracker_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall_i      (stall_i),
  .svc_i        (svc_i),
  .br_take_i    (br_take_i),
  .br_target_i  (br_target_i),
  .fetch_addr_o (fetch_addr_o),
  .opnd_pc_o    (opnd_pc_o),
  .link_addr_o  (link_addr_o),
  .link_we_o    (link_we_o),
  .stage_vld_o  (stage_vld_o)
);

// File: tb/pc_tracker_tb.sv
module pc_tracker_tb;
  localparam int NROW = 20;

  typedef struct packed {
    logic        stall;
    logic        svc;
    logic        br;
    logic [31:0] tgt;
    logic [31:0] e_fetch;
    logic [2:0]  e_vld;
    logic [31:0] e_opnd;
    logic        e_lwe;
    logic [31:0] e_link;
  } row_t;

  // Rows are cycles after reset release; inputs are applied and outputs checked in the same row.
  localparam row_t TBL [NROW] = '{
    {1'b0,1'b0,1'b0,32'h0,   32'h0,   3'b000,32'h0,  1'b0,32'h0},   // c0  reset state
    {1'b0,1'b0,1'b0,32'h0,   32'h4,   3'b001,32'h0,  1'b0,32'h0},   // c1
    {1'b0,1'b0,1'b0,32'h0,   32'h8,   3'b011,32'h0,  1'b0,32'h0},   // c2
    {1'b1,1'b0,1'b0,32'h0,   32'hC,   3'b111,32'h8,  1'b0,32'h0},   // c3  stall
    {1'b0,1'b1,1'b0,32'h0,   32'hC,   3'b111,32'h8,  1'b1,32'h4},   // c4  SVC at 0x0
    {1'b0,1'b1,1'b1,32'h300, 32'h8,   3'b000,32'h0,  1'b0,32'h0},   // c5  SVC+br on invalid exe
    {1'b0,1'b0,1'b0,32'h0,   32'hC,   3'b001,32'h0,  1'b0,32'h0},   // c6
    {1'b0,1'b0,1'b0,32'h0,   32'h10,  3'b011,32'h0,  1'b0,32'h0},   // c7
    {1'b0,1'b0,1'b1,32'h103, 32'h14,  3'b111,32'h10, 1'b0,32'h0},   // c8  branch, unaligned target
    {1'b0,1'b0,1'b0,32'h0,   32'h100, 3'b000,32'h0,  1'b0,32'h0},   // c9
    {1'b0,1'b0,1'b0,32'h0,   32'h104, 3'b001,32'h0,  1'b0,32'h0},   // c10
    {1'b0,1'b0,1'b0,32'h0,   32'h108, 3'b011,32'h0,  1'b0,32'h0},   // c11
    {1'b0,1'b1,1'b1,32'h200, 32'h10C, 3'b111,32'h108,1'b1,32'h104}, // c12 SVC and branch together
    {1'b0,1'b0,1'b0,32'h0,   32'h8,   3'b000,32'h0,  1'b0,32'h0},   // c13
    {1'b1,1'b0,1'b0,32'h0,   32'hC,   3'b001,32'h0,  1'b0,32'h0},   // c14 stall
    {1'b0,1'b0,1'b0,32'h0,   32'hC,   3'b001,32'h0,  1'b0,32'h0},   // c15
    {1'b0,1'b0,1'b0,32'h0,   32'h10,  3'b011,32'h0,  1'b0,32'h0},   // c16
    {1'b1,1'b1,1'b0,32'h0,   32'h14,  3'b111,32'h10, 1'b0,32'h0},   // c17 SVC under stall
    {1'b0,1'b1,1'b0,32'h0,   32'h14,  3'b111,32'h10, 1'b1,32'hC},   // c18 SVC after stall
    {1'b0,1'b0,1'b0,32'h0,   32'h8,   3'b000,32'h0,  1'b0,32'h0}    // c19
  };

  logic        clk, rst_n, stall_i, svc_i, br_take_i;
  logic [31:0] br_target_i, fetch_addr_o, opnd_pc_o, link_addr_o;
  logic        link_we_o;
  logic [2:0]  stage_vld_o;
  int          n_chk, n_bad;
  logic        done;

  pc_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .svc_i(svc_i),
    .br_take_i(br_take_i), .br_target_i(br_target_i),
    .fetch_addr_o(fetch_addr_o), .opnd_pc_o(opnd_pc_o),
    .link_addr_o(link_addr_o), .link_we_o(link_we_o), .stage_vld_o(stage_vld_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; stall_i = 1'b0; svc_i = 1'b0; br_take_i = 1'b0; br_target_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 fetch in reset", fetch_addr_o, 32'h0);
    chk("R1 valid in reset", 32'(stage_vld_o), 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      row_t r;
      r = TBL[i];
      stall_i = r.stall; svc_i = r.svc; br_take_i = r.br; br_target_i = r.tgt;
      #1;
      // R2 sequencing, R5 vector, R6 branch target, R7 stall, R8 priority, R9 invalid exe
      chk($sformatf("R2/R5/R6/R7/R8/R9 fetch row %0d", i), fetch_addr_o, r.e_fetch);
      chk($sformatf("R2/R5/R6/R7 valid row %0d", i), 32'(stage_vld_o), 32'(r.e_vld));
      if (r.e_vld[2])
        chk($sformatf("R3 operand row %0d", i), opnd_pc_o, r.e_opnd);
      chk($sformatf("R4/R7/R9 strobe row %0d", i), 32'(link_we_o), 32'(r.e_lwe));
      if (r.e_lwe)
        chk($sformatf("R4/R8 link row %0d", i), link_addr_o, r.e_link);
      @(negedge clk);
    end
    stall_i = 1'b0; svc_i = 1'b0; br_take_i = 1'b0;
    // directed: asynchronous reset in mid-run, no clock edge in between (R1)
    #2;
    chk("R1 pre-reset valid nonzero", 32'(stage_vld_o != 3'b000), 32'h1);
    rst_n = 1'b0;
    #1;
    chk("R1 async fetch", fetch_addr_o, 32'h0);
    chk("R1 async valid", 32'(stage_vld_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // directed: restart from zero after reset (R2, R3)
    chk("R2 restart fetch", fetch_addr_o, 32'hC);
    chk("R2 restart valid", 32'(stage_vld_o), 32'h7);
    chk("R3 restart operand", opnd_pc_o, 32'h8);
    done = 1'b1;
    finish_run();
  end
endmodule